// File: doc/BRIEF.md
# Receive Queue with Fill-Level Triggers

This block is the receive-side holding queue of a serial port. A character receiver hands it one word per cycle: nine data bits, a parity-error tag and a framing-error tag. The host takes words from the head. The head is always visible on the read port, and a one-cycle read strobe removes it. The queue holds `DEPTH` entries (16 by default). A word that arrives while the queue is full is dropped, and a sticky overrun flag records the loss.

Two programmable fill levels shape the flow signals. The receive trigger level drives a threshold flag. The flow-control trigger level drives an active-low request-to-send output that tells the far end to stop. Running tallies report how many stored entries carry each error tag. An idle timer, clocked by the receiver's bit tick, raises a data-ready flag when a few words have been waiting below the trigger level for too long. A synchronous flush input empties the queue and clears all of its state.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset the fill count, both error tallies, the overrun flag and the data-ready flag are 0.
- R2: Words leave in arrival order. `rd_data`, `rd_perr` and `rd_ferr` always show the oldest stored entry together with its own tags.
- R3: `fill` rises by one on an accepted write and falls by one on a read of a non-empty queue. A write and a read in the same cycle leave it unchanged. A read strobe on an empty queue changes nothing.
- R4: A write while `fill` equals `DEPTH` and no read is strobed is discarded and sets `overrun`. `overrun` then stays 1 until flush or reset. A write together with a read while full is accepted.
- R5: `full_thr` is 1 exactly when `fill >= rx_trig`. It is therefore 1 at any fill when `rx_trig` is 0.
- R6: `rts_n` is 0 while `fill < rts_trig` and 1 when `fill >= rts_trig`.
- R7: `ferr_cnt` and `perr_cnt` equal the number of stored entries whose framing or parity tag is 1. A dropped word does not count.
- R8: After `IDLE_BITS` (15) `bit_tick` pulses with no write strobe and no read strobe, `data_ready` is 1 while `0 < fill <= rx_trig`. Any write or read strobe restarts the timer and clears the flag.
- R9: `data_ready` is 0 whenever the queue is empty or `fill > rx_trig`, however long the line has been idle.
- R10: A one-cycle `flush` empties the queue and zeroes `fill`, both tallies, `overrun` and the idle timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One pulse per serial bit time |
| wr_valid | input | 1 | Write strobe from the receiver |
| wr_data | input | 9 | Received data word |
| wr_perr | input | 1 | Parity-error tag of the word |
| wr_ferr | input | 1 | Framing-error tag of the word |
| rd_pop | input | 1 | Host read strobe; removes the head |
| flush | input | 1 | Empty the queue and clear its state |
| rx_trig | input | 4 | Receive trigger level |
| rts_trig | input | 4 | Flow-control trigger level |
| rd_data | output | 9 | Head data word |
| rd_perr | output | 1 | Head parity-error tag |
| rd_ferr | output | 1 | Head framing-error tag |
| fill | output | 5 | Number of stored entries |
| ferr_cnt | output | 5 | Stored entries tagged with a framing error |
| perr_cnt | output | 5 | Stored entries tagged with a parity error |
| full_thr | output | 1 | Fill is at or above the receive trigger |
| data_ready | output | 1 | Idle timeout with low fill |
| rts_n | output | 1 | Active-low request-to-send |
| overrun | output | 1 | Sticky word-lost flag |

## Verification
The hardest state to reach is a full queue that is offered one more word, both with and without a read strobe in the same cycle. The stimulus writes sixteen tagged words, offers a seventeenth alone, and then offers a write paired with a read. It then drains the queue and checks that the dropped word never appears and that the tallies return to zero. The idle flag needs long quiet stretches at chosen fill levels. The stimulus pulses the bit tick fourteen and then fifteen times at fill levels below, equal to and above the trigger.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int unsigned DATA_W = 9;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } rxq_op_e;

    function automatic rxq_op_e make_op(input logic push, input logic pop);
        return rxq_op_e'({push, pop});
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             do_push,
    input  logic             do_pop,
    input  rxq_entry_t       wr_entry,
    output rxq_entry_t       head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    rxq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case (make_op(do_push, do_pop))
                OP_PUSH: count <= count + 1'b1;
                OP_POP:  count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (do_push && wptr == PTR_W'(i))
                mem[i] <= wr_entry;
        end
    end

    assign head  = mem[rptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/rxq_tally.sv
module rxq_tally #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && !dec)
            cnt <= cnt + 1'b1;
        else if (dec && !inc)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/rxq_idle.sv
module rxq_idle #(
    parameter int unsigned LIMIT = 15,
    localparam int unsigned TW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    output logic expired
);
    logic [TW-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst || restart)
            ticks <= '0;
        else if (tick && ticks != TW'(LIMIT))
            ticks <= ticks + 1'b1;
    end

    assign expired = (ticks == TW'(LIMIT));
endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned IDLE_BITS = 15,
    localparam int unsigned TRIG_W = $clog2(DEPTH),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_perr,
    input  logic              wr_ferr,
    input  logic              rd_pop,
    input  logic              flush,
    input  logic [TRIG_W-1:0] rx_trig,
    input  logic [TRIG_W-1:0] rts_trig,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_perr,
    output logic              rd_ferr,
    output logic [CNT_W-1:0]  fill,
    output logic [CNT_W-1:0]  ferr_cnt,
    output logic [CNT_W-1:0]  perr_cnt,
    output logic              full_thr,
    output logic              data_ready,
    output logic              rts_n,
    output logic              overrun
);
    rxq_entry_t in_e, head_e;
    logic       full, empty, push_ok, pop_ok, idle_done;

    assign in_e    = '{data: wr_data, perr: wr_perr, ferr: wr_ferr};
    assign pop_ok  = rd_pop && !empty;
    assign push_ok = wr_valid && (!full || rd_pop);

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .clr(flush),
        .do_push(push_ok), .do_pop(pop_ok),
        .wr_entry(in_e), .head(head_e),
        .count(fill), .full(full), .empty(empty)
    );

    rxq_tally #(.CNT_W(CNT_W)) u_ferr (
        .clk(clk), .rst(rst), .clr(flush),
        .inc(push_ok && wr_ferr), .dec(pop_ok && head_e.ferr),
        .cnt(ferr_cnt)
    );

    rxq_tally #(.CNT_W(CNT_W)) u_perr (
        .clk(clk), .rst(rst), .clr(flush),
        .inc(push_ok && wr_perr), .dec(pop_ok && head_e.perr),
        .cnt(perr_cnt)
    );

    rxq_idle #(.LIMIT(IDLE_BITS)) u_idle (
        .clk(clk), .rst(rst),
        .restart(flush || wr_valid || rd_pop),
        .tick(bit_tick), .expired(idle_done)
    );

    always_ff @(posedge clk) begin
        if (rst || flush)
            overrun <= 1'b0;
        else if (wr_valid && full && !rd_pop)
            overrun <= 1'b1;
    end

    assign rd_data    = head_e.data;
    assign rd_perr    = head_e.perr;
    assign rd_ferr    = head_e.ferr;
    assign full_thr   = (fill >= CNT_W'(rx_trig));
    assign rts_n      = (fill >= CNT_W'(rts_trig));
    assign data_ready = idle_done && !empty && (fill <= CNT_W'(rx_trig));
endmodule

// File: rtl/rx_fifo_trig_chk.sv
module rx_fifo_trig_chk #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_valid,
    input logic             rd_pop,
    input logic             flush,
    input logic [CNT_W-1:0] fill,
    input logic [CNT_W-1:0] ferr_cnt,
    input logic [CNT_W-1:0] perr_cnt,
    input logic             overrun,
    input logic             data_ready
);
    // R3
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(DEPTH));
    // R3
    fill_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !rd_pop && !flush && fill < CNT_W'(DEPTH)) |=> fill == $past(fill) + 1'b1);
    // R4
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !rd_pop && !flush && fill == CNT_W'(DEPTH)) |=> overrun);
    // R4
    ovr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun && !flush) |=> overrun);
    // R7
    tally_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ferr_cnt <= fill && perr_cnt <= fill);
    // R9
    dr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        data_ready |-> fill != '0);
    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fill == '0 && ferr_cnt == '0 && perr_cnt == '0 && !overrun));
endmodule

bind rx_fifo_trig rx_fifo_trig_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .rd_pop(rd_pop),
    .flush(flush), .fill(fill), .ferr_cnt(ferr_cnt), .perr_cnt(perr_cnt),
    .overrun(overrun), .data_ready(data_ready)
);

// File: tb/sim_rx_fifo_trig.sv
module sim_rx_fifo_trig;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0, wr_valid = 1'b0, wr_perr = 1'b0, wr_ferr = 1'b0;
    logic       rd_pop = 1'b0, flush = 1'b0;
    logic [8:0] wr_data = '0;
    logic [3:0] rx_trig = 4'd4, rts_trig = 4'd8;
    logic [8:0] rd_data;
    logic       rd_perr, rd_ferr, full_thr, data_ready, rts_n, overrun;
    logic [4:0] fill, ferr_cnt, perr_cnt;

    int n_chk = 0, n_bad = 0;
    logic [10:0] exp_q[$];
    bit exp_ovr = 0;

    always #4 clk = ~clk;

    rx_fifo_trig u0 (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_perr(wr_perr), .wr_ferr(wr_ferr),
        .rd_pop(rd_pop), .flush(flush), .rx_trig(rx_trig), .rts_trig(rts_trig),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .fill(fill),
        .ferr_cnt(ferr_cnt), .perr_cnt(perr_cnt), .full_thr(full_thr),
        .data_ready(data_ready), .rts_n(rts_n), .overrun(overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model_tags(input int bitpos);
        int n = 0;
        foreach (exp_q[i]) n += int'(exp_q[i][bitpos]);
        return n;
    endfunction

    // Scoreboard monitor: compares the head on every read strobe (R2).
    initial forever begin
        @(negedge clk);
        #2;
        if (rd_pop && !flush && exp_q.size() > 0) begin
            logic [10:0] e;
            e = exp_q.pop_front();
            chk("R2 head data", int'(rd_data), int'(e[10:2]));
            chk("R2 head perr", int'(rd_perr), int'(e[1]));
            chk("R2 head ferr", int'(rd_ferr), int'(e[0]));
        end
    end

    task automatic push(input logic [8:0] d, input logic p, input logic f, input logic with_pop);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d; wr_perr = p; wr_ferr = f; rd_pop = with_pop;
        if (exp_q.size() < DEPTH || with_pop) exp_q.push_back({d, p, f});
        else exp_ovr = 1;
        @(negedge clk);
        wr_valid = 1'b0; rd_pop = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
        end
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        exp_q.delete(); exp_ovr = 0;
    endtask

    task automatic chk_model(input string tag);
        chk({tag, " R3 fill"}, int'(fill), exp_q.size());
        chk({tag, " R7 ferr"}, int'(ferr_cnt), model_tags(0));
        chk({tag, " R7 perr"}, int'(perr_cnt), model_tags(1));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 fill", int'(fill), 0);
        chk("R1 ferr", int'(ferr_cnt), 0);
        chk("R1 perr", int'(perr_cnt), 0);
        chk("R1 overrun", int'(overrun), 0);
        chk("R1 data_ready", int'(data_ready), 0);
        chk("R6 rts empty", int'(rts_n), 0);
        chk("R5 thr empty", int'(full_thr), 0);

        // R3 read strobe on empty queue changes nothing
        pop();
        chk("R3 empty pop", int'(fill), 0);

        // Mixed tags
        push(9'h1A5, 1, 0, 0);
        chk("R2 show-ahead", int'(rd_data), 'h1A5);
        push(9'h042, 0, 1, 0);
        push(9'h0FF, 1, 1, 0);
        chk("R5 fill3 trig4", int'(full_thr), 0);
        push(9'h100, 0, 0, 0);
        chk("R5 fill4 trig4", int'(full_thr), 1);
        push(9'h013, 0, 1, 0);
        chk_model("five");
        chk("R6 fill5 trig8", int'(rts_n), 0);
        pop(); pop();
        chk_model("after two reads");
        chk("R5 fill3 again", int'(full_thr), 0);
        push(9'h155, 1, 0, 1);
        chk_model("push with pop");

        // R8 idle timeout at fill 3 <= 4
        ticks(14);
        chk("R8 14 ticks", int'(data_ready), 0);
        ticks(1);
        chk("R8 15 ticks", int'(data_ready), 1);
        push(9'h0AA, 0, 0, 0);
        chk("R8 restart on write", int'(data_ready), 0);
        ticks(15);
        chk("R8 fill equals trig", int'(data_ready), 1);
        pop();
        chk("R8 restart on read", int'(data_ready), 0);
        push(9'h0BB, 0, 1, 0);
        push(9'h0CC, 1, 0, 0);
        ticks(15);
        chk("R9 fill above trig", int'(data_ready), 0);
        while (exp_q.size() > 0) pop();
        chk_model("drained");
        ticks(15);
        chk("R9 empty idle", int'(data_ready), 0);

        // Fill to the top, R6 threshold, R4 overrun
        for (int i = 0; i < DEPTH; i++) begin
            push(9'(i * 37 + 5), 1'(i % 3 == 0), 1'(i % 4 == 1), 0);
            if (i == 6) chk("R6 fill7 trig8", int'(rts_n), 0);
            if (i == 7) chk("R6 fill8 trig8", int'(rts_n), 1);
        end
        chk_model("full");
        chk("R4 no overrun yet", int'(overrun), 0);
        push(9'h1FF, 1, 1, 0);
        chk("R4 overrun set", int'(overrun), int'(exp_ovr));
        chk_model("after drop");
        push(9'h077, 0, 1, 1);
        chk_model("full push with pop");
        while (exp_q.size() > 0) pop();
        chk_model("drained full");
        chk("R4 overrun sticky", int'(overrun), 1);

        // R10 flush mid-fill
        push(9'h011, 1, 1, 0);
        push(9'h022, 1, 0, 0);
        do_flush();
        chk("R10 fill", int'(fill), 0);
        chk("R10 ferr", int'(ferr_cnt), 0);
        chk("R10 perr", int'(perr_cnt), 0);
        chk("R10 overrun", int'(overrun), 0);
        push(9'h133, 0, 0, 0);
        chk("R10 head after flush", int'(rd_data), 'h133);

        // R5 zero trigger level
        do_flush();
        rx_trig = 4'd0;
        @(negedge clk);
        chk("R5 trig0 empty", int'(full_thr), 1);

        summary();
    end
endmodule